// File: doc/BRIEF.md
# PWM Match Timer

A free-running up-counter with a programmable clock divider in front of it and a bank of compare registers behind it. Each compare register can reset the counter, halt it, or raise a sticky interrupt flag when the counter reaches its value. The last compare register normally sets the period: with its reset flag on, the counter climbs from 0 to that value and starts over. The other compare registers each drive one single-edge PWM pin. The pin is pulled low when a new cycle begins and returns high once the counter reaches the channel's compare value. The waveform is therefore active-low, and the time spent low is the duty value in counter ticks.

Software programs the block through a plain synchronous write port: one address, one data word and one strobe per cycle. Compare values take effect as soon as they are written. There is no shadow copy, so a value written in the middle of a period applies within that same period.

Top module: `pwm_match_timer`

## Requirements
- R1: While `rst_n` is low the counter and divider are 0, every PWM pin is high and every interrupt flag is clear.
- R2: The counter moves only while the run bit (address 0, bit 0) is 1. With the run bit at 0, `count_o` keeps its value.
- R3: With divider value P (address 1), the counter advances once every P+1 clocks.
- R4: Address 2 holds three control bits for each compare channel k: bit 3k enables the interrupt, bit 3k+1 enables reset, and bit 3k+2 enables stop. When a tick arrives while the counter equals compare value k (address 8+k) and that channel's reset bit is set, the counter becomes 0. The period is therefore the compare value plus one tick.
- R5: When the counter becomes 0, every PWM-enabled pin whose compare value is nonzero is driven low. The PWM enable for pin k is address 3, bit k.
- R6: When the counter becomes equal to a PWM-enabled channel's compare value, that pin goes high and stays high for the rest of the cycle.
- R7: A PWM-enabled channel with compare value 0 holds its pin high and never falls.
- R8: A compare value above the period top never matches, so that pin stays low for the whole cycle.
- R9: A match on a channel with its stop bit set clears the run bit, and the counter does not advance on that tick. Writing the run bit back to 1 resumes counting.
- R10: A match on a channel with its interrupt bit set sets flag k in `irq_flags_o`. The flag stays set until 1 is written to bit k at address 4. Writing 0 to a bit leaves that flag as it is. `irq_o` is the OR of all the flags.
- R11: A pin whose PWM enable is 0 keeps its level whatever the counter does.
- R12: With no reset flag set, the counter rolls over from its maximum value to 0, and that rollover starts a new PWM cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Register write data |
| pwm_o | output | N_MATCH-1 | Active-low PWM pins, one per non-period channel |
| count_o | output | CNT_W | Current counter value |
| irq_flags_o | output | N_MATCH | Sticky match flags, one per channel |
| irq_o | output | 1 | Any match flag set |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit divider, four compare channels and a 16-bit data word. The narrow counter brings a natural rollover from 255 to 0 within a few hundred cycles, so the cycle start without any reset flag can be observed directly. The small divider allows divide-by-two spacing to be checked tick by tick. Four channels leave room for one period channel and three pins. Those pins are set up as a zero duty value, an ordinary duty value and a duty value beyond the top, all in the same run.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
   localparam int ADDR_W    = 4;
   localparam int MAX_MATCH = 8;
   // register addresses
   localparam int A_CTRL    = 0;
   localparam int A_PRESC   = 1;
   localparam int A_MCTRL   = 2;
   localparam int A_PWMEN   = 3;
   localparam int A_FLAGS   = 4;
   localparam int A_MATCH0  = 8;
   // per-channel control bit offsets within the control word
   localparam int MC_BITS   = 3;
   localparam int MC_IRQ    = 0;
   localparam int MC_RST    = 1;
   localparam int MC_STOP   = 2;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
   parameter int PRE_W = 32,
   parameter int PW    = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] div_val,
   output logic          tick
);
   generate
      if (PRE_W == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [PW-1:0] pc_q;
         assign tick = run && (pc_q >= div_val);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pc_q <= '0;
            else if (tick)  pc_q <= '0;
            else if (run)   pc_q <= pc_q + PW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_any,
   input  logic             halt_any,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_nxt,
   output logic             step
);
   assign step = tick && (clr_any || !halt_any);

   always_comb begin
      count_nxt = count_q;
      if (tick) begin
         if (clr_any)        count_nxt = '0;
         else if (!halt_any) count_nxt = count_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_nxt;
   end
endmodule

// File: rtl/pmt_pwm_pin.sv
module pmt_pwm_pin #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pen,
   input  logic             step,
   input  logic [CNT_W-1:0] nxt,
   input  logic [CNT_W-1:0] mval,
   output logic             pin_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b1;
      end else if (pen && step) begin
         if (nxt == mval)    pin_q <= 1'b1;
         else if (nxt == '0) pin_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
   import pmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 32,
   parameter int N_MATCH = 4,
   parameter int DATA_W  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [pmt_pkg::ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [N_MATCH-2:0]         pwm_o,
   output logic [CNT_W-1:0]           count_o,
   output logic [N_MATCH-1:0]         irq_flags_o,
   output logic                       irq_o
);
   localparam int N_PWM = N_MATCH - 1;
   localparam int PW    = (PRE_W > 0) ? PRE_W : 1;
   localparam int MCW   = MC_BITS * N_MATCH;

   generate
      if (N_MATCH < 2 || N_MATCH > MAX_MATCH) begin : g_bad_nmatch
         $error("N_MATCH out of range");
      end
      if (DATA_W < CNT_W || DATA_W < MCW || DATA_W < PW) begin : g_bad_dw
         $error("DATA_W too narrow for a register field");
      end
      if (CNT_W < 2) begin : g_bad_cw
         $error("CNT_W too small");
      end
   endgenerate

   // write decode
   logic wr_ctrl, wr_presc, wr_mctrl, wr_pwmen, wr_flags;
   assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_presc = wr_en && (wr_addr == ADDR_W'(A_PRESC));
   assign wr_mctrl = wr_en && (wr_addr == ADDR_W'(A_MCTRL));
   assign wr_pwmen = wr_en && (wr_addr == ADDR_W'(A_PWMEN));
   assign wr_flags = wr_en && (wr_addr == ADDR_W'(A_FLAGS));

   // configuration state
   logic                run_q;
   logic [PW-1:0]       presc_q;
   logic [MCW-1:0]      mctrl_q;
   logic [N_PWM-1:0]    pen_q;
   logic [N_MATCH-1:0]  flags_q;
   logic [CNT_W-1:0]    mr_q [N_MATCH];

   // datapath links
   logic                tick;
   logic                step;
   logic [CNT_W-1:0]    count_q;
   logic [CNT_W-1:0]    count_nxt;
   logic [N_MATCH-1:0]  hit;
   logic [N_MATCH-1:0]  stop_hit;
   logic [N_MATCH-1:0]  rst_hit;
   logic [N_MATCH-1:0]  irq_hit;
   logic                stop_any;
   logic                rst_any;

   genvar k;
   generate
      for (k = 0; k < N_MATCH; k++) begin : g_match
         assign hit[k]      = tick && (count_q == mr_q[k]);
         assign irq_hit[k]  = hit[k] && mctrl_q[MC_BITS*k + MC_IRQ];
         assign rst_hit[k]  = hit[k] && mctrl_q[MC_BITS*k + MC_RST];
         assign stop_hit[k] = hit[k] && mctrl_q[MC_BITS*k + MC_STOP];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mr_q[k] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(A_MATCH0 + k)))
               mr_q[k] <= wr_data[CNT_W-1:0];
         end
      end
   endgenerate

   assign stop_any = |stop_hit;
   assign rst_any  = |rst_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         presc_q <= '0;
         mctrl_q <= '0;
         pen_q   <= '0;
         flags_q <= '0;
      end else begin
         if (wr_ctrl)       run_q <= wr_data[0];
         else if (stop_any) run_q <= 1'b0;
         if (wr_presc) presc_q <= wr_data[PW-1:0];
         if (wr_mctrl) mctrl_q <= wr_data[MCW-1:0];
         if (wr_pwmen) pen_q   <= wr_data[N_PWM-1:0];
         flags_q <= (flags_q & ~(wr_flags ? wr_data[N_MATCH-1:0] : '0)) | irq_hit;
      end
   end

   pmt_prescaler #(.PRE_W(PRE_W), .PW(PW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .div_val (presc_q),
      .tick    (tick)
   );

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .clr_any   (rst_any),
      .halt_any  (stop_any),
      .count_q   (count_q),
      .count_nxt (count_nxt),
      .step      (step)
   );

   generate
      for (k = 0; k < N_PWM; k++) begin : g_pin
         pmt_pwm_pin #(.CNT_W(CNT_W)) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pen   (pen_q[k]),
            .step  (step),
            .nxt   (count_nxt),
            .mval  (mr_q[k]),
            .pin_q (pwm_o[k])
         );
      end
   endgenerate

   assign count_o     = count_q;
   assign irq_flags_o = flags_q;
   assign irq_o       = |flags_q;
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker
   import pmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               tick,
   input logic               run_q,
   input logic               stop_any,
   input logic               rst_any,
   input logic               pen0,
   input logic [CNT_W-1:0]   mr0,
   input logic [CNT_W-1:0]   count_o,
   input logic               pwm0,
   input logic [N_MATCH-1:0] irq_flags_o
);
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(count_o));                                      // R2
   AST_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count_o));                                       // R3
   AST_WRAP_ON_RESET_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rst_any |=> (count_o == '0));                                      // R4
   AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_any && !(wr_en && wr_addr == ADDR_W'(A_CTRL))) |=> !run_q);  // R9
   AST_ZERO_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pen0 && mr0 == '0 && pwm0) |=> pwm0);                             // R7
   AST_DISABLED_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !pen0 |=> $stable(pwm0));                                          // R11
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(A_FLAGS))
      |=> ((irq_flags_o & $past(irq_flags_o)) == $past(irq_flags_o)));   // R10
endmodule

bind pwm_match_timer pmt_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .tick        (tick),
   .run_q       (run_q),
   .stop_any    (stop_any),
   .rst_any     (rst_any),
   .pen0        (pen_q[0]),
   .mr0         (mr_q[0]),
   .count_o     (count_o),
   .pwm0        (pwm_o[0]),
   .irq_flags_o (irq_flags_o)
);

// File: tb/sim_pwm_match_timer.sv
module sim_pwm_match_timer;
   localparam int CW = 8, PW = 4, NM = 4, DW = 16, AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NM-2:0] pwm_o;
   logic [CW-1:0] count_o;
   logic [NM-1:0] irq_flags_o;
   logic          irq_o;

   pwm_match_timer #(.CNT_W(CW), .PRE_W(PW), .N_MATCH(NM), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_o(pwm_o), .count_o(count_o), .irq_flags_o(irq_flags_o), .irq_o(irq_o)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      int    cnt;    // -1 = don't care
      int    pins;   // -1 = don't care
      int    flags;  // -1 = don't care
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   task automatic expect_at(int dly, int cnt, int pins, int flags, string tag);
      exp_t e;
      e.at = cyc + dly; e.cnt = cnt; e.pins = pins; e.flags = flags; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic reg_wr(int addr, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected items when their cycle comes due
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
         exp_t e;
         bit bad;
         e = sbq.pop_front();
         bad = (e.at != cyc);
         if (e.cnt >= 0 && int'(count_o) != e.cnt) bad = 1;
         if (e.pins >= 0 && int'(pwm_o) != e.pins) bad = 1;
         if (e.flags >= 0 && (int'(irq_flags_o) != e.flags || irq_o != (e.flags != 0))) bad = 1;
         n_chk++;
         if (bad) begin
            n_fail++;
            $display("FAIL %s @%0d: count=%0d pins=%b flags=%b irq=%b | expected count=%0d pins=%0d flags=%0d",
                     e.tag, cyc, count_o, pwm_o, irq_flags_o, irq_o, e.cnt, e.pins, e.flags);
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      int held;

      // ---- R1: reset state
      rst_n = 1'b0;
      wait_cyc(2);
      expect_at(1, 0, 7, 0, "R1 reset state");
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(2);
      expect_at(1, 0, 7, 0, "R1 idle after reset");
      wait_cyc(3);

      // ---- divide by 2, period 10 ticks, ch0=3, ch1=0, ch2=20 (beyond top)
      reg_wr(1, 1);            // divider P=1
      reg_wr(8, 3);
      reg_wr(9, 0);
      reg_wr(10, 20);
      reg_wr(11, 9);           // period top
      reg_wr(2, 'h600);        // ch3: reset bit 10, irq bit 9
      reg_wr(3, 'h7);          // PWM enable on all three pins
      expect_at(1, 0, 7, 0, "R2 no count before run bit");
      wait_cyc(2);
      reg_wr(0, 1);
      base = cyc;
      expect_at(1,  0, 7, 0, "R3 no tick before P+1 clocks");
      expect_at(2,  1, 7, 0, "R3 first tick after P+1 clocks");
      expect_at(6,  3, 7, 0, "R3 tick spacing");
      expect_at(19, 9, 7, 0, "R4 counter at top");
      expect_at(20, 0, 2, 8, "R5 R7 R8 cycle start, R10 flag set");
      expect_at(21, 0, 2, 8, "R3 counter holds between ticks");
      expect_at(25, 2, 2, 8, "R6 pin low before match");
      expect_at(26, 3, 3, 8, "R6 pin rises on match");
      expect_at(30, 5, 3, 8, "R10 flag sticky");
      expect_at(38, 9, 3, 8, "R8 beyond-top pin stays low");
      expect_at(40, 0, 2, 8, "R4 period of top+1 ticks");
      wait_cyc(41);

      reg_wr(0, 0);
      held = int'(count_o);
      expect_at(6, held, -1, 8, "R2 counter holds with run bit 0");
      wait_cyc(7);
      reg_wr(4, 'h1);
      expect_at(1, -1, -1, 8, "R10 writing 0 to a flag bit keeps it");
      wait_cyc(2);
      reg_wr(4, 'h8);
      expect_at(1, -1, -1, 0, "R10 write-one clears flag");
      wait_cyc(3);

      // ---- stop on match, non-PWM pins frozen
      do_reset();
      wait_cyc(2);
      reg_wr(8, 2);
      reg_wr(9, 5);
      reg_wr(11, 9);
      reg_wr(2, 'h428);        // ch1 stop(5)+irq(3), ch3 reset(10)
      reg_wr(3, 'h1);          // only pin 0 PWM-enabled
      reg_wr(0, 1);
      base = cyc;
      expect_at(5,  5, 7, 0, "R9 count reaches stop value");
      expect_at(6,  5, 7, 2, "R9 stop holds count, R10 flag");
      expect_at(12, 5, 7, 2, "R9 counter stays halted");
      wait_cyc(13);
      reg_wr(2, 'h408);        // drop stop bit on ch1
      reg_wr(0, 1);
      base = cyc;
      expect_at(1,  6, 7, 2, "R9 resume after run bit rewritten");
      expect_at(4,  9, 7, 2, "R9 resumed to top");
      expect_at(5,  0, 6, 2, "R11 disabled pins keep level, R5 pin0 low");
      expect_at(7,  2, 7, 2, "R6 pin0 rises at match");
      wait_cyc(9);

      // ---- natural rollover, no reset flag
      do_reset();
      wait_cyc(2);
      reg_wr(8, 'h80);
      reg_wr(3, 'h1);
      reg_wr(0, 1);
      base = cyc;
      expect_at(255, 255, 7, 0, "R12 counter at maximum");
      expect_at(256, 0,   6, 0, "R12 rollover starts cycle");
      expect_at(383, 127, 6, 0, "R12 pin low before match");
      expect_at(384, 128, 7, 0, "R12 pin rises after rollover");
      wait_cyc(390);

      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d expected items never compared", sbq.size());
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule